// File: doc/BRIEF.md
# Bus Hold Acknowledge Controller

This block is the processor-side half of a bus-ownership handshake. An external master raises a hold request to take over the processor's bus. The controller grants it with a registered acknowledge, but only at a safe point. That point is immediately when the bus is idle. Otherwise it comes at the boundary after the final ready of the current cycle, and never inside a locked run of cycles. While the acknowledge is high, the controller raises float enables for the address, data, byte-enable and control output groups. It also withholds permission for the processor to begin new cycles.

The cycle generator sits outside this block and reports to it through a small set of strobes. A start strobe marks each new cycle, a last-ready strobe marks the final data transfer of a cycle, and a level marks a locked sequence. The acknowledge and float enables go to the pad ring, which does the actual tristating. A separate output-enable tells the pads whether the acknowledge pin itself is driven, which matters in a tristate test mode. Processor reset and init do not stop the handshake. A back-off input is observed but has no influence on the grant.

Top module: `bhold_ctrl`

## Requirements
- R1: With no cycle outstanding and no lock, a hold request seen high at a rising edge raises `hlda` after the following rising edge. The first edge samples the request and the second one updates the acknowledge.
- R2: An outstanding-cycle flag sets at the edge where `cyc_start` is high and clears at the edge where `last_rdy` is high. When both are high, set wins. With the request held high during a cycle, `hlda` rises one edge after the edge that sampled `last_rdy`.
- R3: While `lock_seq` is sampled high, `hlda` is not granted even with the request high and the bus idle. It rises one edge after the edge that samples `lock_seq` low.
- R4: Once granted, `hlda` falls one edge after the edge at which the hold request is sampled low.
- R5: Every bit of `bus_float` is 1 in every clock in which `hlda` is 1. Outside test mode, every bit is 0 in every clock in which `hlda` is 0.
- R6: `backoff` has no effect: grant timing with it high or toggling matches R1 and R2 exactly.
- R7: The request is honoured with R1 timing while `cpu_reset` or `cpu_init` is high. Either of them sampled high clears the outstanding-cycle flag, so a waiting request is granted one edge later.
- R8: With `test_tri` high, `hlda_oe` is 0 when `TEST_FLOATS_HLDA` is 1, and every `bus_float` bit is 1. With `test_tri` low, `hlda_oe` is 1.
- R9: `cyc_go` equals `req_pending` when `hlda` is 0 and either the hold request is low or `lock_seq` is high. In every other case it is 0.
- R10: After `rst_n` is asserted low, `hlda` is 0, all `bus_float` bits are 0, `hlda_oe` is 1 and no cycle is outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the controller's registers |
| hold_req | input | 1 | External master's bus request, active high |
| cyc_start | input | 1 | A processor bus cycle begins at this edge |
| last_rdy | input | 1 | Final ready of the current cycle is present at this edge |
| lock_seq | input | 1 | A locked sequence of cycles is in progress |
| backoff | input | 1 | Sampled back-off indication, ignored by the grant |
| cpu_reset | input | 1 | Processor reset is active |
| cpu_init | input | 1 | Processor init is active |
| test_tri | input | 1 | Tristate test mode |
| req_pending | input | 1 | Processor has an internal request waiting to start a cycle |
| hlda | output | 1 | Hold acknowledge, driven straight from a flip-flop |
| hlda_oe | output | 1 | Pad drive enable for the acknowledge pin |
| bus_float | output | FLOAT_GROUPS | Float enable per output group (address, data, byte enables/parity, control) |
| cyc_go | output | 1 | Permission for the processor to start a new cycle |

## Verification
The assertions assume that the strobes follow cycle order. `last_rdy` is high for a single clock and only while a cycle is outstanding, and `cyc_start` does not appear while the acknowledge is high. The stimulus follows this: cycles start only from the idle state, each cycle's last ready is a one-clock pulse, and a request is held steady until its grant or withdrawal has been observed. The back-off, reset and init inputs are changed freely, because the block must not depend on them for the grant.

// File: rtl/bhold_pkg.sv
package bhold_pkg;

   // Ownership of the processor bus as seen by the grant register.
   typedef enum logic [0:0] {
      GNT_OWNED    = 1'b0,
      GNT_RELEASED = 1'b1
   } gnt_state_e;

   // Inputs registered at each rising edge before the grant decision.
   typedef struct packed {
      logic hold;
      logic lock;
   } smp_t;

   localparam int SMP_W = $bits(smp_t);

endpackage

// File: rtl/bhold_sampler.sv
module bhold_sampler #(
   parameter int WIDTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("bhold_sampler: WIDTH must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end

endmodule

// File: rtl/bhold_cycle_track.sv
module bhold_cycle_track (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_start,
   input  logic last_rdy,
   input  logic abort,
   output logic busy_q
);

   logic busy_d;

   // Abort (reset/init) clears; a new start beats a same-edge last ready.
   always_comb begin
      busy_d = busy_q;
      if (abort)          busy_d = 1'b0;
      else if (cyc_start) busy_d = 1'b1;
      else if (last_rdy)  busy_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_q <= 1'b0;
      else        busy_q <= busy_d;
   end

endmodule

// File: rtl/bhold_grant.sv
module bhold_grant
   import bhold_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  smp_t       smp,
   input  logic       busy_q,
   output gnt_state_e state_q,
   output logic       hlda_q
);

   gnt_state_e state_d;
   logic       boundary;

   // A release point exists only with no cycle outstanding and no lock.
   assign boundary = !busy_q && !smp.lock;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         GNT_OWNED:    if (smp.hold && boundary) state_d = GNT_RELEASED;
         GNT_RELEASED: if (!smp.hold)            state_d = GNT_OWNED;
         default:                                state_d = GNT_OWNED;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= GNT_OWNED;
         hlda_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         hlda_q  <= (state_d == GNT_RELEASED);
      end
   end

endmodule

// File: rtl/bhold_float_drive.sv
module bhold_float_drive #(
   parameter int FLOAT_GROUPS     = 4,
   parameter bit TEST_FLOATS_HLDA = 1'b1
) (
   input  logic                    hlda_q,
   input  logic                    test_tri,
   output logic                    hlda,
   output logic                    hlda_oe,
   output logic [FLOAT_GROUPS-1:0] bus_float
);

   // The acknowledge pin value comes straight from its flip-flop.
   assign hlda = hlda_q;

   generate
      for (genvar g = 0; g < FLOAT_GROUPS; g++) begin : g_grp
         assign bus_float[g] = hlda_q || test_tri;
      end

      if (TEST_FLOATS_HLDA) begin : g_oe_test
         assign hlda_oe = !test_tri;
      end else begin : g_oe_fixed
         assign hlda_oe = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/bhold_ctrl.sv
module bhold_ctrl
   import bhold_pkg::*;
#(
   parameter int FLOAT_GROUPS     = 4,
   parameter bit TEST_FLOATS_HLDA = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    hold_req,
   input  logic                    cyc_start,
   input  logic                    last_rdy,
   input  logic                    lock_seq,
   input  logic                    backoff,
   input  logic                    cpu_reset,
   input  logic                    cpu_init,
   input  logic                    test_tri,
   input  logic                    req_pending,
   output logic                    hlda,
   output logic                    hlda_oe,
   output logic [FLOAT_GROUPS-1:0] bus_float,
   output logic                    cyc_go
);

   generate
      if (FLOAT_GROUPS < 1 || FLOAT_GROUPS > 16) begin : g_bad_groups
         $error("bhold_ctrl: FLOAT_GROUPS must lie in 1..16");
      end
   endgenerate

   smp_t       smp_d, smp_q;
   logic       busy_q;
   logic       hlda_q;
   gnt_state_e gnt_state;

   assign smp_d.hold = hold_req;
   assign smp_d.lock = lock_seq;

   bhold_sampler #(.WIDTH(SMP_W)) u_smp (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (smp_d),
      .q     (smp_q)
   );

   bhold_cycle_track u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .cyc_start (cyc_start),
      .last_rdy  (last_rdy),
      .abort     (cpu_reset || cpu_init),
      .busy_q    (busy_q)
   );

   bhold_grant u_gnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .smp     (smp_q),
      .busy_q  (busy_q),
      .state_q (gnt_state),
      .hlda_q  (hlda_q)
   );

   bhold_float_drive #(
      .FLOAT_GROUPS     (FLOAT_GROUPS),
      .TEST_FLOATS_HLDA (TEST_FLOATS_HLDA)
   ) u_drv (
      .hlda_q    (hlda_q),
      .test_tri  (test_tri),
      .hlda      (hlda),
      .hlda_oe   (hlda_oe),
      .bus_float (bus_float)
   );

   // A pending request yields to a hold request unless a lock must finish.
   assign cyc_go = req_pending && !hlda_q && (!hold_req || lock_seq);

endmodule

// File: rtl/bhold_ctrl_chk.sv
module bhold_ctrl_chk #(
   parameter int FLOAT_GROUPS = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    hold_req,
   input logic                    lock_seq,
   input logic                    backoff,
   input logic                    cpu_reset,
   input logic                    cpu_init,
   input logic                    test_tri,
   input logic                    hlda_q,
   input logic                    busy_q,
   input logic [FLOAT_GROUPS-1:0] bus_float,
   input logic                    cyc_go,
   input logic                    hlda_oe
);

   p_rise_needs_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hlda_q) |-> $past(hold_req, 2));

   p_rise_after_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hlda_q) |-> !$past(busy_q));

   p_no_grant_in_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hlda_q) |-> !$past(lock_seq, 2));

   p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hlda_q && !hold_req) |=> ##1 !hlda_q);

   p_float_with_hlda_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hlda_q |-> (&bus_float));

   p_backoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hlda_q) && $past(backoff, 2)) |-> $past(hold_req, 2));

   p_abort_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_reset || cpu_init) |=> !busy_q);

   p_driven_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !test_tri |-> hlda_oe);

   p_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hlda_q |-> !cyc_go);

endmodule

bind bhold_ctrl bhold_ctrl_chk #(.FLOAT_GROUPS(FLOAT_GROUPS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hold_req  (hold_req),
   .lock_seq  (lock_seq),
   .backoff   (backoff),
   .cpu_reset (cpu_reset),
   .cpu_init  (cpu_init),
   .test_tri  (test_tri),
   .hlda_q    (hlda_q),
   .busy_q    (busy_q),
   .bus_float (bus_float),
   .cyc_go    (cyc_go),
   .hlda_oe   (hlda_oe)
);

// File: tb/tb_bhold_ctrl.sv
`timescale 1ns/1ps
module tb_bhold_ctrl;

   localparam int NG = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          hold_req, cyc_start, last_rdy, lock_seq, backoff;
   logic          cpu_reset, cpu_init, test_tri, req_pending;
   logic          hlda, hlda_oe, cyc_go;
   logic [NG-1:0] bus_float;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   always #4 clk = ~clk;

   bhold_ctrl #(.FLOAT_GROUPS(NG), .TEST_FLOATS_HLDA(1'b1)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .hold_req    (hold_req),
      .cyc_start   (cyc_start),
      .last_rdy    (last_rdy),
      .lock_seq    (lock_seq),
      .backoff     (backoff),
      .cpu_reset   (cpu_reset),
      .cpu_init    (cpu_init),
      .test_tri    (test_tri),
      .req_pending (req_pending),
      .hlda        (hlda),
      .hlda_oe     (hlda_oe),
      .bus_float   (bus_float),
      .cyc_go      (cyc_go)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // One rising edge; returns at the following falling edge.
   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic idle_inputs();
      hold_req = 0; cyc_start = 0; last_rdy = 0; lock_seq = 0; backoff = 0;
      cpu_reset = 0; cpu_init = 0; test_tri = 0; req_pending = 0;
   endtask

   task automatic release_bus();
      hold_req = 0;
      tick(3);
   endtask

   // Start one cycle from idle: cyc_start high for a single edge.
   task automatic start_cycle();
      cyc_start = 1; tick(); cyc_start = 0;
   endtask

   task automatic t_reset();
      idle_inputs();
      rst_n = 0;
      tick(2);
      rst_n = 1;
      req_pending = 1;
      #1;
      check("R10 hlda", hlda, 0);
      check("R10 float", bus_float, 0);
      check("R10 oe", hlda_oe, 1);
      check("R9 go idle", cyc_go, 1);
      req_pending = 0;
      hold_req = 1;
      tick(2);
      check("R10 no outstanding cycle, grant", hlda, 1);
      release_bus();
   endtask

   task automatic t_idle_grant();
      hold_req = 1; req_pending = 1;
      #1 check("R9 go blocked by hold", cyc_go, 0);
      tick();
      check("R1 not yet", hlda, 0);
      tick();
      check("R1 granted", hlda, 1);
      check("R5 float all", bus_float, {NG{1'b1}});
      check("R9 go blocked by hlda", cyc_go, 0);
      hold_req = 0;
      #1 check("R9 hlda still blocks", cyc_go, 0);
      tick();
      check("R4 still held", hlda, 1);
      tick();
      check("R4 released", hlda, 0);
      check("R5 float off", bus_float, 0);
      check("R9 go resumes", cyc_go, 1);
      req_pending = 0;
   endtask

   task automatic t_busy_grant();
      start_cycle();
      hold_req = 1;
      tick(4);
      check("R2 wait for cycle", hlda, 0);
      check("R5 float off while busy", bus_float, 0);
      last_rdy = 1; tick(); last_rdy = 0;
      check("R2 not yet at last ready", hlda, 0);
      tick();
      check("R2 granted after last ready", hlda, 1);
      release_bus();
      check("R4 released after cycle", hlda, 0);
   endtask

   task automatic t_lock();
      lock_seq = 1; hold_req = 1; req_pending = 1;
      #1 check("R9 go inside lock", cyc_go, 1);
      req_pending = 0;
      tick(5);
      check("R3 held off by lock", hlda, 0);
      lock_seq = 0;
      tick();
      check("R3 not yet after lock", hlda, 0);
      tick();
      check("R3 granted after lock", hlda, 1);
      release_bus();
   endtask

   task automatic t_backoff();
      backoff = 1; hold_req = 1;
      tick();
      check("R6 idle not yet", hlda, 0);
      backoff = 0;
      tick();
      check("R6 idle granted", hlda, 1);
      release_bus();
      start_cycle();
      backoff = 1; hold_req = 1;
      tick(3);
      check("R6 busy still waits", hlda, 0);
      last_rdy = 1; tick(); last_rdy = 0; backoff = 0;
      check("R6 busy not yet", hlda, 0);
      tick();
      check("R6 busy granted", hlda, 1);
      release_bus();
   endtask

   task automatic t_reset_init();
      cpu_reset = 1; hold_req = 1;
      tick();
      check("R7 reset not yet", hlda, 0);
      tick();
      check("R7 granted in reset", hlda, 1);
      cpu_reset = 0;
      release_bus();
      start_cycle();
      hold_req = 1;
      tick(2);
      check("R7 busy waits", hlda, 0);
      cpu_init = 1; tick(); cpu_init = 0;
      check("R7 init not yet", hlda, 0);
      tick();
      check("R7 init clears cycle", hlda, 1);
      release_bus();
   endtask

   task automatic t_test_mode();
      test_tri = 1;
      #1;
      check("R8 oe off", hlda_oe, 0);
      check("R8 float all", bus_float, {NG{1'b1}});
      check("R8 hlda", hlda, 0);
      test_tri = 0;
      #1;
      check("R8 oe back", hlda_oe, 1);
      check("R5 float off", bus_float, 0);
   endtask

   initial begin
      t_reset();
      t_idle_grant();
      t_busy_grant();
      t_lock();
      t_backoff();
      t_reset_init();
      t_test_mode();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual running expected done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule